// File: doc/BRIEF.md
# Paged Address Translator with Table-Length Check

This block converts a logical word address into a physical word address. The page table sits in on-chip registers, and the page size is a power of two. The low bits of a logical address are the offset within a page. The bits above them name the page. Each table entry holds a frame number and a mapped flag. The physical address is the frame number placed above the unchanged offset.

Only a privileged write port can change the table. That port writes single entries and a table-length register. The lookup side can only read. Every lookup compares its page number with the length register. It also tests the entry's mapped flag. A lookup that passes both tests returns a physical address. A lookup that fails either test raises a fault, and the address output stays at zero.

The lookup is registered: a request presented in one cycle produces its result in the next cycle. After reset the length register is zero and every entry is unmapped, so every lookup faults until supervisor software programs the table.

Top module: `pgx_translator`

## Requirements
- R1: While reset is held, and until the first lookup after reset, `out_valid`, `out_fault` and `out_addr` are all zero. Reset sets the length register to 0 and clears every entry's mapped flag, so any lookup made before programming faults.
- R2: A logical address is split into two fields. The offset is bits [OFF_W-1:0] and the page number is bits [OFF_W+PAGE_W-1:OFF_W]. The offset appears unchanged in bits [OFF_W-1:0] of the physical address.
- R3: A lookup that passes both checks returns `frame * 2^OFF_W + offset` with `out_fault` low. With the default sizes and pages 0, 1 and 2 mapped to frames 3, 6 and 4, logical 5'b01_001 gives 7'b0110_001 and logical 5'b10_111 gives 7'b0100_111.
- R4: A lookup whose page number is greater than or equal to the length register faults, whatever the entry contents.
- R5: A lookup whose page number is below the length but whose entry mapped flag is 0 faults.
- R6: The result (`out_valid`, `out_fault`, `out_addr`) appears exactly one cycle after `lk_valid` is sampled high. In any cycle with `out_valid` low, `out_fault` and `out_addr` are zero.
- R7: An entry write takes effect for a lookup issued in the next cycle. A lookup in the same cycle as the write still sees the previous contents.
- R8: The length register is PAGE_W+1 bits wide and holds values from 0 to 2^PAGE_W. A length of 0 makes every lookup fault, and a length of 2^PAGE_W admits every page.
- R9: A fault and a translated address never appear together. When `out_fault` is high, `out_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_we | input | 1 | Privileged write strobe for one table entry |
| tbl_page | input | PAGE_W | Entry index written |
| tbl_frame | input | FRAME_W | Frame number stored in the entry |
| tbl_mapped | input | 1 | Mapped flag stored in the entry |
| len_we | input | 1 | Privileged write strobe for the length register |
| len_val | input | PAGE_W+1 | New table length (number of admissible pages) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | OFF_W+PAGE_W | Logical word address |
| out_valid | output | 1 | Result present (one cycle after request) |
| out_fault | output | 1 | Lookup rejected (out of range or unmapped) |
| out_addr | output | FRAME_W+OFF_W | Physical word address, zero when no valid translation |

## Verification
The bench sweeps all 32 logical addresses several times, each time against a different table state:
- the reset state, which must fault everywhere;
- the three-page example map, which checks the frame/offset join and the length fault on page 3;
- a full-length table that contains one unmapped entry, which keeps the mapped-flag fault apart from the length fault.

It then steps the length register from 0 to 4 with every entry mapped, checking the pages on each side of the limit. A write and a lookup aimed at the same entry in the same cycle show that the old frame is returned first and the new frame on the following cycle. Idle cycles between lookups check that no stale result or fault is left on the outputs.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

  // Outcome of a single lookup, decided before the output register.
  typedef enum logic [1:0] {
    PGX_PASS      = 2'd0,
    PGX_OVER_LEN  = 2'd1,
    PGX_UNMAPPED  = 2'd2
  } pgx_verdict_e;

endpackage

// File: rtl/pgx_table.sv
module pgx_table #(
  parameter int PAGE_W  = 2,
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PAGE_W-1:0]  wr_page,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic               wr_mapped,
  input  logic [PAGE_W-1:0]  rd_page,
  output logic [FRAME_W-1:0] rd_frame,
  output logic               rd_mapped
);

  localparam int NUM_PAGES = 1 << PAGE_W;

  logic [FRAME_W-1:0] frame_q  [NUM_PAGES];
  logic [NUM_PAGES-1:0] mapped_q;

  // One storage slot per page; only the privileged port writes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PAGES; i++) frame_q[i] <= '0;
      mapped_q <= '0;
    end else if (wr_en) begin
      frame_q[wr_page]  <= wr_frame;
      mapped_q[wr_page] <= wr_mapped;
    end
  end

  assign rd_frame  = frame_q[rd_page];
  assign rd_mapped = mapped_q[rd_page];

endmodule

// File: rtl/pgx_len_reg.sv
module pgx_len_reg #(
  parameter int PAGE_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PAGE_W:0] wr_val,
  output logic [PAGE_W:0] len_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     len_q <= '0;
    else if (wr_en) len_q <= wr_val;
  end

endmodule

// File: rtl/pgx_bound.sv
module pgx_bound #(
  parameter int PAGE_W = 2
) (
  input  logic                  [PAGE_W-1:0] page,
  input  logic                  [PAGE_W:0]   len,
  input  logic                               mapped,
  output pgx_pkg::pgx_verdict_e              verdict
);

  import pgx_pkg::*;

  // Range test has priority: an entry past the length is never consulted.
  function automatic logic below_len(input logic [PAGE_W-1:0] p,
                                     input logic [PAGE_W:0]   l);
    return {1'b0, p} < l;
  endfunction

  always_comb begin
    if (!below_len(page, len)) verdict = PGX_OVER_LEN;
    else if (!mapped)          verdict = PGX_UNMAPPED;
    else                       verdict = PGX_PASS;
  end

endmodule

// File: rtl/pgx_translator.sv
module pgx_translator #(
  parameter int OFF_W   = 3,
  parameter int PAGE_W  = 2,
  parameter int FRAME_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tbl_we,
  input  logic [PAGE_W-1:0]          tbl_page,
  input  logic [FRAME_W-1:0]         tbl_frame,
  input  logic                       tbl_mapped,
  input  logic                       len_we,
  input  logic [PAGE_W:0]            len_val,
  input  logic                       lk_valid,
  input  logic [OFF_W+PAGE_W-1:0]    lk_addr,
  output logic                       out_valid,
  output logic                       out_fault,
  output logic [FRAME_W+OFF_W-1:0]   out_addr
);

  import pgx_pkg::*;

  localparam int LA_W = OFF_W + PAGE_W;
  localparam int PA_W = FRAME_W + OFF_W;

  function automatic logic [PAGE_W-1:0] page_of(input logic [LA_W-1:0] a);
    return a[LA_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] offset_of(input logic [LA_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] join_phys(input logic [FRAME_W-1:0] f,
                                                input logic [OFF_W-1:0]   o);
    return {f, o};
  endfunction

  // Named internal events, visible to the bound checker.
  logic [PAGE_W-1:0]  lk_page;
  logic [OFF_W-1:0]   lk_off;
  logic [FRAME_W-1:0] rd_frame;
  logic               rd_mapped;
  logic [PAGE_W:0]    len_q;
  pgx_verdict_e       verdict;
  logic               xl_pass;

  assign lk_page = page_of(lk_addr);
  assign lk_off  = offset_of(lk_addr);

  pgx_table #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_we),
    .wr_page   (tbl_page),
    .wr_frame  (tbl_frame),
    .wr_mapped (tbl_mapped),
    .rd_page   (lk_page),
    .rd_frame  (rd_frame),
    .rd_mapped (rd_mapped)
  );

  pgx_len_reg #(.PAGE_W(PAGE_W)) u_len (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (len_we),
    .wr_val (len_val),
    .len_q  (len_q)
  );

  pgx_bound #(.PAGE_W(PAGE_W)) u_bound (
    .page    (lk_page),
    .len     (len_q),
    .mapped  (rd_mapped),
    .verdict (verdict)
  );

  assign xl_pass = (verdict == PGX_PASS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= lk_valid;
      out_fault <= lk_valid && !xl_pass;
      out_addr  <= (lk_valid && xl_pass) ? join_phys(rd_frame, lk_off) : '0;
    end
  end

endmodule

// File: rtl/pgx_translator_chk.sv
module pgx_translator_chk #(
  parameter int OFF_W   = 3,
  parameter int PAGE_W  = 2,
  parameter int FRAME_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lk_valid,
  input logic [OFF_W+PAGE_W-1:0]  lk_addr,
  input logic [PAGE_W-1:0]        lk_page,
  input logic [PAGE_W:0]          len_q,
  input logic                     rd_mapped,
  input logic [FRAME_W-1:0]       rd_frame,
  input logic                     out_valid,
  input logic                     out_fault,
  input logic [FRAME_W+OFF_W-1:0] out_addr
);

  localparam int PA_W = FRAME_W + OFF_W;

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_fault) |-> out_addr[OFF_W-1:0] == $past(lk_addr[OFF_W-1:0]));

  assert_frame_used_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_fault) |-> out_addr[PA_W-1:OFF_W] == $past(rd_frame));

  assert_over_len_faults_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && ({1'b0, lk_page} >= len_q)) |=> out_fault);

  assert_unmapped_faults_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !rd_mapped) |=> out_fault);

  assert_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> out_valid);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_fault && out_addr == '0));

  assert_fault_no_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> out_addr == '0);

endmodule

bind pgx_translator pgx_translator_chk #(
  .OFF_W(OFF_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_addr   (lk_addr),
  .lk_page   (lk_page),
  .len_q     (len_q),
  .rd_mapped (rd_mapped),
  .rd_frame  (rd_frame),
  .out_valid (out_valid),
  .out_fault (out_fault),
  .out_addr  (out_addr)
);

// File: tb/pgx_translator_tb.sv
module pgx_translator_tb;

  localparam int OFF_W   = 3;
  localparam int PAGE_W  = 2;
  localparam int FRAME_W = 4;
  localparam int LA_W    = OFF_W + PAGE_W;
  localparam int PA_W    = FRAME_W + OFF_W;
  localparam int NPG     = 1 << PAGE_W;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               tbl_we = 1'b0;
  logic [PAGE_W-1:0]  tbl_page = '0;
  logic [FRAME_W-1:0] tbl_frame = '0;
  logic               tbl_mapped = 1'b0;
  logic               len_we = 1'b0;
  logic [PAGE_W:0]    len_val = '0;
  logic               lk_valid = 1'b0;
  logic [LA_W-1:0]    lk_addr = '0;
  logic               out_valid;
  logic               out_fault;
  logic [PA_W-1:0]    out_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Bench-side model of the programmed state.
  int m_frame [NPG];
  bit m_map   [NPG];
  int m_len;

  always #4 clk = ~clk; // 125 MHz

  pgx_translator #(.OFF_W(OFF_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_page(tbl_page), .tbl_frame(tbl_frame), .tbl_mapped(tbl_mapped),
    .len_we(len_we), .len_val(len_val),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .out_valid(out_valid), .out_fault(out_fault), .out_addr(out_addr)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic put_entry(input int pg, input int fr, input bit mp);
    @(negedge clk);
    tbl_we = 1'b1; tbl_page = PAGE_W'(pg); tbl_frame = FRAME_W'(fr); tbl_mapped = mp;
    @(negedge clk);
    tbl_we = 1'b0;
    m_frame[pg] = fr; m_map[pg] = mp;
  endtask

  task automatic put_len(input int l);
    @(negedge clk);
    len_we = 1'b1; len_val = (PAGE_W+1)'(l);
    @(negedge clk);
    len_we = 1'b0;
    m_len = l;
  endtask

  // Expected result computed arithmetically: page = a / 2^OFF_W, offset = a mod 2^OFF_W.
  task automatic expect_result(input int a);
    int pg, off, ex;
    bit ok;
    string tag;
    pg  = a / (1 << OFF_W);
    off = a % (1 << OFF_W);
    ok  = (pg < m_len) && m_map[pg];
    ex  = ok ? m_frame[pg] * (1 << OFF_W) + off : 0;
    if (pg >= m_len)     tag = (m_len == 0) ? "R8" : "R4";
    else if (!m_map[pg]) tag = "R5";
    else                 tag = "R3";
    check("R6", int'(out_valid), 1, "out_valid");
    check(tag, int'(out_fault), ok ? 0 : 1, "out_fault");
    check(ok ? "R2" : "R9", int'(out_addr), ex, "out_addr");
  endtask

  task automatic look(input int a);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = LA_W'(a);
    @(negedge clk);
    lk_valid = 1'b0;
    expect_result(a);
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R6", int'(out_valid), 0, "idle out_valid");
    check("R6", int'(out_fault), 0, "idle out_fault");
    check("R6", int'(out_addr), 0, "idle out_addr");
  endtask

  task automatic sweep();
    for (int a = 0; a < (1 << LA_W); a++) look(a);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NPG; i++) begin m_frame[i] = 0; m_map[i] = 1'b0; end
    m_len = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1", int'(out_valid), 0, "reset out_valid");
    check("R1", int'(out_fault), 0, "reset out_fault");
    check("R1", int'(out_addr), 0, "reset out_addr");
    rst_n = 1'b1;
    idle_check();
    // R1/R8: unprogrammed table faults everywhere
    sweep();

    // R3: example map, length 3, page 3 out of range (R4)
    put_entry(0, 3, 1'b1);
    put_entry(1, 6, 1'b1);
    put_entry(2, 4, 1'b1);
    put_len(3);
    look(5'b01_001);
    check("R3", int'(out_addr), 7'b0110_001, "example 01_001");
    look(5'b10_111);
    check("R3", int'(out_addr), 7'b0100_111, "example 10_111");
    sweep();
    idle_check();

    // R5: full length, page 3 unmapped
    put_len(4);
    sweep();
    put_entry(3, 15, 1'b1);
    sweep();
    put_entry(0, 3, 1'b0);
    sweep();
    put_entry(0, 0, 1'b1);

    // R8/R4: step the length across the full range, all mapped
    for (int l = 0; l <= NPG; l++) begin
      put_len(l);
      sweep();
    end

    // R7: write and lookup together on page 1 (old frame 6 -> new frame 9)
    @(negedge clk);
    tbl_we = 1'b1; tbl_page = 2'd1; tbl_frame = 4'd9; tbl_mapped = 1'b1;
    lk_valid = 1'b1; lk_addr = 5'b01_010;
    @(negedge clk);
    tbl_we = 1'b0;
    check("R7", int'(out_addr), 6 * 8 + 2, "same-cycle lookup sees old frame");
    lk_addr = 5'b01_010;
    @(negedge clk);
    lk_valid = 1'b0;
    check("R7", int'(out_addr), 9 * 8 + 2, "next-cycle lookup sees new frame");
    m_frame[1] = 9;
    sweep();
    idle_check();

    // R1: reset again clears length and mappings
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_len = 0;
    for (int i = 0; i < NPG; i++) m_map[i] = 1'b0;
    look(5'b00_000);
    check("R1", int'(out_fault), 1, "fault after re-reset");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule